// File: doc/BRIEF.md
# Clock Stop Controller for PCI Outputs

This block builds a set of PCI bus clocks from a single reference clock that runs at four times the slow PCI rate. Some outputs always run at the slow rate, which is the reference divided by four. The other outputs each have their own select bit that picks the slow rate or the fast rate, which is the reference divided by two. Every output comes straight from a register and has a 50 percent duty cycle.

An asynchronous, active-low stop request passes through a synchronizer. It parks every output that is running at the slow rate in the low state. When the request is released, those outputs resume with a whole high phase. Outputs at the fast rate do not react to the stop request.

Stopping, restarting and select changes all take effect only at phase boundaries, so no shortened pulse ever reaches an output. A system uses the block to gate the slow PCI clocks for power saving, while clocks that serve fast links keep running.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every output is low. Every select is taken as slow. With `stop_n` high, the first reference edge after reset is released starts a slow high phase on every fixed output.
- R2: When not stopped, a fixed output, or a selectable output whose select bit is 0, repeats a pattern of 2 reference cycles high followed by 2 low.
- R3: A selectable output whose select bit is 1 toggles on every reference cycle, giving 1 cycle high and 1 cycle low.
- R4: While `stop_n` is held low, every fixed output and every selectable output whose select bit is 0 sits low.
- R5: A selectable output whose select bit is 1 keeps toggling at the fast rate whatever the level of `stop_n`.
- R6: If `stop_n` falls just after a rising edge of a fixed output, exactly one further rising edge appears on that output before it halts. A change of the internal run state only happens while the slow outputs are low.
- R7: After `stop_n` returns high, a stopped slow output rises within 8 reference cycles. Its first high phase lasts the full 2 cycles.
- R8: Changing a select bit at any time never produces a high interval other than 1 or 2 reference cycles. A select bit is sampled only at the boundary where both rates are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at four times the slow output rate |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Asynchronous active-low stop request for slow outputs |
| sel_i | input | N_SEL | Per-output rate select, 1 = fast (ref/2), 0 = slow (ref/4) |
| fix_o | output | N_FIX | Fixed slow-rate clock outputs |
| sel_clk_o | output | N_SEL | Rate-selectable clock outputs |

## Verification
A table of stop and select combinations is held long enough to settle. For each combination, rising edges are counted on every output over a fixed window. This separates the slow rate, the fast rate and the parked state, and shows whether the stop request reaches only the lanes that are at the slow rate. Directed runs line the stop request up with a rising edge to count the edges that still get through. They also time the first pulse after release. Select bits are then toggled freely, with the stop request both released and held, while a monitor measures every high interval to catch runt or stretched pulses.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int PH_W = 2;
  typedef logic [PH_W-1:0] phase_t;

  // phase 3 is low for both rates, so reset parks the counter there
  localparam phase_t PH_RST     = 2'd3;
  // last slow-high state: run state is refreshed as slow outputs fall
  localparam phase_t PH_RUN_UPD = 2'd1;
  // both rates low: select bits may be taken
  localparam phase_t PH_SEL_UPD = 2'd3;

  function automatic logic hi_slow(phase_t p);
    return ~p[1];
  endfunction

  function automatic logic hi_fast(phase_t p);
    return ~p[0];
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase
  import clkstop_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  output phase_t ph_nxt,
  output logic   run,
  output logic   sel_win
);
  phase_t ph_q;

  assign ph_nxt  = ph_q + phase_t'(1);
  assign sel_win = (ph_q == PH_SEL_UPD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_RST;
      run  <= 1'b1;
    end else begin
      ph_q <= ph_nxt;
      if (ph_q == PH_RUN_UPD) run <= go;
    end
  end
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane
  import clkstop_pkg::*;
#(
  parameter bit SELECTABLE = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_t ph_nxt,
  input  logic   run,
  input  logic   sel_win,
  input  logic   sel_req,
  output logic   clk_o,
  output logic   fast_o
);
  logic fast_nxt;

  generate
    if (SELECTABLE) begin : g_sel
      logic fast_q;
      always_ff @(posedge clk) begin
        if (rst)          fast_q <= 1'b0;
        else if (sel_win) fast_q <= sel_req;
      end
      assign fast_nxt = sel_win ? sel_req : fast_q;
      assign fast_o   = fast_q;
    end else begin : g_fix
      logic unused_in;
      assign unused_in = sel_req ^ sel_win;
      assign fast_nxt  = 1'b0;
      assign fast_o    = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_o <= 1'b0;
    else     clk_o <= fast_nxt ? hi_fast(ph_nxt) : (run & hi_slow(ph_nxt));
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_FIX       = 2,
  parameter int N_SEL       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_n,
  input  logic [N_SEL-1:0] sel_i,
  output logic [N_FIX-1:0] fix_o,
  output logic [N_SEL-1:0] sel_clk_o
);
  localparam int N_LANE = N_FIX + N_SEL;

  logic   go;
  logic   run;
  logic   sel_win;
  phase_t ph_nxt;
  logic [N_LANE-1:0] lane_req;
  logic [N_LANE-1:0] lane_clk;
  logic [N_LANE-1:0] lane_fast;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst(rst), .d_async(stop_n), .q(go)
  );

  clkstop_phase phase_i (
    .clk(clk), .rst(rst), .go(go),
    .ph_nxt(ph_nxt), .run(run), .sel_win(sel_win)
  );

  assign lane_req = {sel_i, {N_FIX{1'b0}}};

  generate
    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
      clkstop_lane #(.SELECTABLE(i >= N_FIX)) lane_i (
        .clk(clk), .rst(rst), .ph_nxt(ph_nxt), .run(run),
        .sel_win(sel_win), .sel_req(lane_req[i]),
        .clk_o(lane_clk[i]), .fast_o(lane_fast[i])
      );
    end
  endgenerate

  assign fix_o     = lane_clk[N_FIX-1:0];
  assign sel_clk_o = lane_clk[N_LANE-1:N_FIX];
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int N_FIX = 2,
  parameter int N_SEL = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   run,
  input logic [N_FIX+N_SEL-1:0] lane_clk,
  input logic [N_FIX+N_SEL-1:0] lane_fast
);
  AST_RESET_LOW: assert property (@(posedge clk) rst |=> (lane_clk == '0)); // R1

  generate
    for (genvar i = 0; i < N_FIX + N_SEL; i++) begin : g_chk
      AST_SLOW_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($rose(lane_clk[i]) && !lane_fast[i]) |=> lane_clk[i]); // R7
      AST_NO_WIDE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($past(lane_clk[i]) && lane_clk[i]) |=> !lane_clk[i]); // R2
      AST_FAST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (lane_fast[i] && $past(lane_fast[i])) |-> (lane_clk[i] != $past(lane_clk[i]))); // R5
      AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run) && !lane_fast[i]) |-> !lane_clk[i]); // R4
      AST_RUN_AT_LOW: assert property (@(posedge clk) disable iff (rst)
        ((run != $past(run)) && !lane_fast[i]) |-> !lane_clk[i]); // R6
    end
  endgenerate
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_FIX(N_FIX), .N_SEL(N_SEL)) chk_i (
  .clk(clk), .rst(rst), .run(run), .lane_clk(lane_clk), .lane_fast(lane_fast)
);

// File: tb/clkstop_ctrl_tb_top.sv
module clkstop_ctrl_tb_top;
  localparam int N_FIX = 2;
  localparam int N_SEL = 2;
  localparam int N_ALL = N_FIX + N_SEL;
  localparam int N_VEC = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_n = 1'b1;
  logic [N_SEL-1:0] sel_i = '0;
  logic [N_FIX-1:0] fix_o;
  logic [N_SEL-1:0] sel_clk_o;

  int checks = 0;
  int errors = 0;
  int rises  [N_ALL];
  int hi_len [N_ALL];
  int bad_hi [N_ALL];
  logic [N_ALL-1:0] prev = '0;
  logic [N_ALL-1:0] all_o;

  // {stop_n, sel[1:0], fixed rises, sel0 rises, sel1 rises} over 8 cycles
  localparam logic [11:0] VEC [N_VEC] = '{
    {1'b1, 2'b00, 3'd2, 3'd2, 3'd2},
    {1'b1, 2'b01, 3'd2, 3'd4, 3'd2},
    {1'b0, 2'b01, 3'd0, 3'd4, 3'd0},
    {1'b0, 2'b11, 3'd0, 3'd4, 3'd4},
    {1'b0, 2'b10, 3'd0, 3'd0, 3'd4},
    {1'b1, 2'b11, 3'd2, 3'd4, 3'd4},
    {1'b0, 2'b00, 3'd0, 3'd0, 3'd0}
  };

  assign all_o = {sel_clk_o, fix_o};

  clkstop_ctrl #(.N_FIX(N_FIX), .N_SEL(N_SEL)) dut_i (
    .clk(clk), .rst(rst), .stop_n(stop_n), .sel_i(sel_i),
    .fix_o(fix_o), .sel_clk_o(sel_clk_o)
  );

  always #5 clk = ~clk;

  initial begin
    for (int k = 0; k < N_ALL; k++) begin
      rises[k] = 0; hi_len[k] = 0; bad_hi[k] = 0;
    end
  end

  // pulse monitor, samples at the falling edge
  always @(negedge clk) begin
    for (int k = 0; k < N_ALL; k++) begin
      if (all_o[k] && !prev[k]) rises[k]++;
      if (all_o[k]) hi_len[k]++;
      else begin
        if (prev[k]) begin
          if (k < N_FIX && hi_len[k] != 2) bad_hi[k]++;
          if (k >= N_FIX && hi_len[k] != 1 && hi_len[k] != 2) bad_hi[k]++;
        end
        hi_len[k] = 0;
      end
    end
    prev = all_o;
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_tests();
    int base [N_ALL];
    int n;
    int extra;
    logic p;
    // reset state
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 outputs low in reset", int'(all_o), 0);
    rst = 1'b0;
    tick();
    chk("R1 first edge starts high", int'(fix_o), 3);
    tick();
    chk("R2 high lasts 2 cycles", int'(fix_o), 3);
    tick();
    chk("R2 low after 2 high", int'(fix_o), 0);

    // table of stop/select patterns
    for (int v = 0; v < N_VEC; v++) begin
      logic st;
      st     = VEC[v][11];
      stop_n = st;
      sel_i  = VEC[v][10:9];
      repeat (12) tick();
      if (!st) chk("R4 fixed parked low", int'(fix_o), 0);
      for (int k = 0; k < N_ALL; k++) base[k] = rises[k];
      repeat (8) tick();
      for (int k = 0; k < N_FIX; k++)
        chk(st ? "R2 fixed rate" : "R4 fixed stopped", rises[k] - base[k], int'(VEC[v][8:6]));
      chk(VEC[v][9] ? (st ? "R3 sel0 fast" : "R5 sel0 fast ignores stop")
                    : (st ? "R2 sel0 slow" : "R4 sel0 stopped"),
          rises[N_FIX] - base[N_FIX], int'(VEC[v][5:3]));
      chk(VEC[v][10] ? (st ? "R3 sel1 fast" : "R5 sel1 fast ignores stop")
                     : (st ? "R2 sel1 slow" : "R4 sel1 stopped"),
          rises[N_FIX+1] - base[N_FIX+1], int'(VEC[v][2:0]));
    end

    // stop latency aligned to a rising edge
    stop_n = 1'b1; sel_i = '0;
    repeat (12) tick();
    p = fix_o[0];
    for (int c = 0; c < 8; c++) begin
      tick();
      if (fix_o[0] && !p) break;
      p = fix_o[0];
    end
    stop_n = 1'b0;
    extra = 0;
    p = fix_o[0];
    for (int c = 0; c < 16; c++) begin
      tick();
      if (fix_o[0] && !p) extra++;
      p = fix_o[0];
    end
    chk("R6 one rising edge after stop", extra, 1);
    chk("R4 low after stop", int'(fix_o[0]), 0);

    // restart shape
    stop_n = 1'b1;
    n = 0;
    for (int c = 0; c < 20; c++) begin
      tick();
      n++;
      if (fix_o[0]) break;
    end
    chk("R7 restart within 8 cycles", int'(n <= 8), 1);
    tick();
    chk("R7 first high is full width", int'(fix_o[0]), 1);
    tick();
    chk("R7 first high ends after 2", int'(fix_o[0]), 0);

    // select changes at arbitrary times, running and stopped
    for (int c = 0; c < 64; c++) begin
      if (c % 3 == 0) sel_i = sel_i + 1'b1;
      tick();
    end
    stop_n = 1'b0;
    for (int c = 0; c < 64; c++) begin
      if (c % 5 == 0) sel_i = sel_i + 1'b1;
      tick();
    end
    for (int k = 0; k < N_FIX; k++) chk("R2 fixed high widths", bad_hi[k], 0);
    for (int k = N_FIX; k < N_ALL; k++) chk("R8 select change widths", bad_hi[k], 0);

    // reset again with stop held and fast selects
    sel_i = '1;
    rst = 1'b1;
    tick();
    tick();
    chk("R1 reset clears all outputs", int'(all_o), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual hang expected finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule